// File: doc/BRIEF.md
# Round-Robin Sample Distributor and Collector

This block takes one stream of samples and deals them out to K parallel processing rows, one sample per row in a fixed rotation, then gathers the rows' results back into a single stream using the same rotation. Because the gather side visits the rows in the order the deal side filled them, the merged output keeps the input order. This holds even when the rows have different latencies or start at staggered times.

Both sides use a valid/ready handshake. The deal pointer moves only when the selected row takes a sample. The gather pointer moves only when the selected row hands over a result and the downstream consumer takes it. A row that is slow or full stalls its own side; it is never skipped. A launch-spacing parameter keeps the deal side idle for a set number of cycles after each accepted sample. This staggers the start times of successive rows. With K rows and a per-row period of K·(GAP+1) cycles, the aggregate rate reaches K times the rate of one row.

Top module: `rr_spread_merge`

## Requirements
- R1: While in reset and at the first cycle after it, both rotation pointers select row 0. With no input offered, `row_in_valid` is all zero. With `out_ready` high, `row_out_ready` is 1 on bit 0 only.
- R2: Accepted samples go to rows 0, 1, …, K-1 and then wrap to row 0. The first sample after reset goes to row 0.
- R3: `in_ready` equals the ready of the currently selected row, gated by the spacing counter. The ready inputs of the other rows have no effect. The deal pointer holds whenever no sample is accepted.
- R4: Every row sees `in_data` on its slice of `row_in_data`. Only the selected row's bit of `row_in_valid` can be high, and it is high only when `in_valid` is high and the spacing window has elapsed.
- R5: `out_valid` and `out_data` come from the currently selected row's slice (`row_out_data[r*W +: W]`). The gather pointer advances through rows 0 … K-1 and wraps, one step per output handshake.
- R6: When the selected row has no result, `out_valid` is low even if other rows hold results. The gather pointer does not move.
- R7: `row_out_ready` has at most one bit set. That bit is the selected row's bit, and it is set only while `out_ready` is high.
- R8: For GAP cycles after each accepted sample, `in_ready` is low.
- R9: With rows of different latencies, the merged output carries every accepted sample exactly once, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample accepted this cycle when valid |
| in_data | input | W | Input sample |
| row_in_valid | output | K | Per-row sample strobe (one-hot) |
| row_in_ready | input | K | Per-row ability to take a sample |
| row_in_data | output | K*W | Sample copy for each row |
| row_out_valid | input | K | Per-row result available |
| row_out_ready | output | K | Per-row result taken |
| row_out_data | input | K*W | Per-row result |
| out_valid | output | 1 | Merged result available |
| out_ready | input | 1 | Downstream takes the merged result |
| out_data | output | W | Merged result |

## Verification
The hardest case to reach is a gather stall while another row is already holding a finished result. Here the out-of-order row must wait and must not overtake. The bench gives the four rows latencies of 3, 7, 2 and 5 cycles, so row 2 regularly finishes before row 1. It also adds random per-row holds on both sides and random downstream backpressure. This makes the selected row late while its neighbours are ready. Every cycle, the bench compares `in_ready`, `out_valid` and `row_out_ready` against values predicted from its own pointer model, and it checks the merged sequence number by number.

// File: rtl/rr_spread_merge.sv
module rr_spread_merge #(
  parameter int K   = 4,
  parameter int W   = 16,
  parameter int GAP = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  output logic [K-1:0]   row_in_valid,
  input  logic [K-1:0]   row_in_ready,
  output logic [K*W-1:0] row_in_data,
  input  logic [K-1:0]   row_out_valid,
  output logic [K-1:0]   row_out_ready,
  input  logic [K*W-1:0] row_out_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data
);
  localparam int PW = (K > 1) ? $clog2(K) : 1;
  localparam int GW = (GAP > 0) ? $clog2(GAP + 1) : 1;
  localparam logic [PW-1:0] LAST = PW'(K - 1);

  logic [PW-1:0] wptr, rptr;
  logic [GW-1:0] gap_cnt;
  logic          open_slot, fire_in, fire_out;

  assign open_slot = (gap_cnt == '0);
  assign in_ready  = open_slot && row_in_ready[wptr];
  assign fire_in   = in_valid && in_ready;
  assign out_valid = row_out_valid[rptr];
  assign out_data  = row_out_data[rptr*W +: W];
  assign fire_out  = out_valid && out_ready;

  for (genvar r = 0; r < K; r++) begin : g_row
    assign row_in_data[r*W +: W] = in_data;
    assign row_in_valid[r]  = in_valid && open_slot && (wptr == PW'(r));
    assign row_out_ready[r] = out_ready && (rptr == PW'(r));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      gap_cnt <= '0;
    end else begin
      if (fire_in) begin
        wptr    <= (wptr == LAST) ? '0 : wptr + 1'b1;
        gap_cnt <= GW'(GAP);
      end else if (!open_slot) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
      if (fire_out)
        rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end
  end

  assert_in_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire_in |=> wptr == (($past(wptr) == LAST) ? '0 : $past(wptr) + 1'b1));
  assert_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_in |=> $stable(wptr));
  assert_out_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire_out |=> rptr == (($past(rptr) == LAST) ? '0 : $past(rptr) + 1'b1));
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_out |=> $stable(rptr));
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_in_valid) && $onehot0(row_out_ready));
  if (GAP > 0) begin : g_gap_chk
    assert_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire_in |=> !in_ready);
  end
endmodule

// File: tb/rr_spread_merge_test.sv
module rr_spread_merge_test;
  localparam int K = 4, W = 16, GAP = 1, N = 400, DEPTH = 8;
  localparam int LAT [K] = '{3, 7, 2, 5};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [W-1:0] in_data = '0;
  logic [K-1:0] row_in_valid, row_in_ready, row_out_valid, row_out_ready;
  logic [K*W-1:0] row_in_data, row_out_data;
  logic out_valid, in_ready;
  logic [W-1:0] out_data;

  rr_spread_merge #(.K(K), .W(W), .GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .row_in_valid(row_in_valid), .row_in_ready(row_in_ready), .row_in_data(row_in_data),
    .row_out_valid(row_out_valid), .row_out_ready(row_out_ready), .row_out_data(row_out_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  always #5 clk = ~clk;

  int vectors = 0, errors = 0, cyc = 0, sent = 0, recv = 0;
  int exp_w = 0, exp_r = 0, gap_m = 0;
  bit run = 0;
  logic [W-1:0] bd [K][DEPTH];
  int bt [K][DEPTH];
  int bw [K], br [K], bc [K];
  logic [K-1:0] hold_in = '0, hold_out = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  initial for (int r = 0; r < K; r++) begin bw[r] = 0; br[r] = 0; bc[r] = 0; end

  always @(negedge clk) begin
    if (run) begin
      bit rnd;
      rnd = (sent >= 100);
      for (int r = 0; r < K; r++) begin
        hold_in[r]  = rnd && ($urandom_range(0, 3) == 0);
        hold_out[r] = rnd && ($urandom_range(0, 3) == 0);
      end
      in_valid  = (sent < N) && (!rnd || $urandom_range(0, 2) != 0);
      in_data   = W'(sent);
      out_ready = !rnd || ($urandom_range(0, 2) != 0);
    end else begin
      hold_in = '0; hold_out = '0; in_valid = 0; out_ready = 1;
    end
    for (int r = 0; r < K; r++) begin
      row_in_ready[r]  = (bc[r] < DEPTH) && !hold_in[r];
      row_out_valid[r] = (bc[r] > 0) && (cyc >= bt[r][br[r]] + LAT[r]) && !hold_out[r];
      row_out_data[r*W +: W] = (bc[r] > 0) ? bd[r][br[r]] : W'(16'hDEAD);
    end
  end

  always @(posedge clk) begin
    if (rst_n && run) begin
      bit fin;
      bit fout;
      fin  = in_valid && in_ready;
      fout = out_valid && out_ready;
      chk(in_ready == ((gap_m == 0) && row_in_ready[exp_w]), "R3/R8 in_ready", in_ready, exp_w);
      chk(row_in_valid == ((in_valid && gap_m == 0) ? K'(1) << exp_w : '0), "R2/R4 row_in_valid", row_in_valid, exp_w);
      chk(out_valid == row_out_valid[exp_r], "R5/R6 out_valid", out_valid, exp_r);
      chk(row_out_ready == (out_ready ? K'(1) << exp_r : '0), "R7 row_out_ready", row_out_ready, exp_r);
      if (fin) begin
        chk(row_in_data[exp_w*W +: W] == in_data, "R4 row_in_data", row_in_data[exp_w*W +: W], in_data);
        bd[exp_w][bw[exp_w]] = in_data;
        bt[exp_w][bw[exp_w]] = cyc;
        bw[exp_w] = (bw[exp_w] + 1) % DEPTH;
        bc[exp_w]++;
        exp_w = (exp_w + 1) % K;
        sent++;
        gap_m = GAP;
      end else if (gap_m > 0) gap_m--;
      if (fout) begin
        chk(out_data == W'(recv), "R9 order", out_data, recv);
        recv++;
      end
      for (int r = 0; r < K; r++)
        if (row_out_valid[r] && row_out_ready[r]) begin
          br[r] = (br[r] + 1) % DEPTH;
          bc[r]--;
        end
      if (fout) exp_r = (exp_r + 1) % K;
    end
    cyc++;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(row_in_valid == '0 && out_valid == 0, "R1 reset strobes", row_in_valid, 0);
    chk(row_out_ready == 4'b0001, "R1 reset gather row", row_out_ready, 1);
    chk(in_ready == 1, "R1 reset in_ready", in_ready, 1);
    @(negedge clk); rst_n = 1; run = 1;
    fork
      begin : wd
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", recv, N);
      end
      begin
        wait (recv == N);
        disable wd;
      end
    join_any
    disable fork;
    repeat (20) @(posedge clk);
    chk(recv == N && sent == N, "R9 completeness", recv, N);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule